// File: doc/BRIEF.md
# Fixed Task Graph Sequencer

This block drives one hard-wired acyclic graph of four tasks, called A, B, C and D, where task A runs twice. It waits for an application request. It then issues one-cycle start pulses to the tasks and reacts to the one-cycle finish pulses they return. After the first run of A, tasks B and C run side by side. When B finishes, A is started a second time. Task D may start only once that second run of A and task C have both finished. When D finishes, the sequencer raises a done flag.

Each pair of tasks that can run at once has its own states. One state covers the case where B finishes first, another where C finishes first, and another where both finish in the same cycle. The same holds for the second run of A and task C. So every order of the concurrent finish events, including a tie, leads to the correct next request. Finish pulses from tasks that are not running are ignored.

Top module: `taskGraphSeq`

## Requirements
- R1: After reset, `taskReq` is 0, `appDone` is low, and the sequencer waits in its idle state.
- R2: In the idle state, an `appReq` pulse produces a pulse on `taskReq[0]` (task A) in the following cycle.
- R3: When the first run of A finishes, `taskReq[1]` (B) and `taskReq[2]` (C) pulse together in the next cycle. Neither of them ever pulses without the other.
- R4: A finish of B produces a pulse on `taskReq[0]` in the next cycle for the second run of A. This holds whether B finishes before C, after C, or in the same cycle as C.
- R5: `taskReq[3]` (D) pulses in the cycle after the later of two events: the second run of A finishes, and C finishes. If both finish in the same cycle, D pulses in the next cycle. D never pulses together with another request.
- R6: Every request bit is high for exactly one cycle per start.
- R7: A bit of `finish` is ignored when its task is not running. An `appReq` is ignored while tasks are in progress. Neither changes any later output.
- R8: The cycle after D finishes, `appDone` goes high. It stays high until reset or until `appReq` is seen. No request pulses are issued while `appDone` is high.
- R9: `appReq` while `appDone` is high returns the sequencer to idle. In the next cycle `appDone` is low and no request pulses. A further `appReq` then starts a new run with task A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| appReq | input | 1 | Application request pulse |
| finish | input | 4 | Task finish pulses, bit 0 = A, 1 = B, 2 = C, 3 = D |
| taskReq | output | 4 | Registered one-cycle start pulses, same bit order as `finish` |
| appDone | output | 1 | High while the graph is complete |

## Verification
The critical coincidence is two tasks finishing in the same cycle. This happens for B and C while they run together, and for the second run of A and C at the join in front of D. Directed runs drive both finish bits in one cycle and drive each single order. Random runs drive all four finish bits with a random chance every cycle, so ties and stray pulses happen often. The bench model keeps its own set of running tasks and join bits. Its expected requests and done flag are compared with the outputs every cycle.

// File: rtl/tgsPkg.sv
package tgsPkg;

  localparam int NUM_TASKS = 4;
  localparam int TASK_A = 0;
  localparam int TASK_B = 1;
  localparam int TASK_C = 2;
  localparam int TASK_D = 3;

  // Progress through the fixed graph; names list the tasks still running
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_A1    = 4'd1,
    ST_BC    = 4'd2,
    ST_AC    = 4'd3,
    ST_B     = 4'd4,
    ST_A2    = 4'd5,
    ST_C     = 4'd6,
    ST_D     = 4'd7,
    ST_DONE  = 4'd8
  } phase_t;

  typedef struct packed {
    logic [NUM_TASKS-1:0] start;
    logic                 setDone;
    logic                 clrDone;
  } strobe_t;

endpackage

// File: rtl/tgsControl.sv
module tgsControl
  import tgsPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 appReq,
  input  logic [NUM_TASKS-1:0] finish,
  output strobe_t              strobe,
  output phase_t               phase
);

  phase_t phaseNext;
  logic finA, finB, finC, finD;

  assign finA = finish[TASK_A];
  assign finB = finish[TASK_B];
  assign finC = finish[TASK_C];
  assign finD = finish[TASK_D];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext      = phase;
    strobe         = '0;
    unique case (phase)
      ST_IDLE: begin
        if (appReq) begin
          phaseNext            = ST_A1;
          strobe.start[TASK_A] = 1'b1;
        end
      end
      ST_A1: begin
        if (finA) begin
          phaseNext            = ST_BC;
          strobe.start[TASK_B] = 1'b1;
          strobe.start[TASK_C] = 1'b1;
        end
      end
      ST_BC: begin
        unique case ({finB, finC})
          2'b10: begin
            phaseNext            = ST_AC;
            strobe.start[TASK_A] = 1'b1;
          end
          2'b01: phaseNext = ST_B;
          2'b11: begin
            phaseNext            = ST_A2;
            strobe.start[TASK_A] = 1'b1;
          end
          default: phaseNext = ST_BC;
        endcase
      end
      ST_B: begin
        if (finB) begin
          phaseNext            = ST_A2;
          strobe.start[TASK_A] = 1'b1;
        end
      end
      ST_AC: begin
        unique case ({finA, finC})
          2'b10: phaseNext = ST_C;
          2'b01: phaseNext = ST_A2;
          2'b11: begin
            phaseNext            = ST_D;
            strobe.start[TASK_D] = 1'b1;
          end
          default: phaseNext = ST_AC;
        endcase
      end
      ST_C: begin
        if (finC) begin
          phaseNext            = ST_D;
          strobe.start[TASK_D] = 1'b1;
        end
      end
      ST_A2: begin
        if (finA) begin
          phaseNext            = ST_D;
          strobe.start[TASK_D] = 1'b1;
        end
      end
      ST_D: begin
        if (finD) begin
          phaseNext      = ST_DONE;
          strobe.setDone = 1'b1;
        end
      end
      ST_DONE: begin
        if (appReq) begin
          phaseNext      = ST_IDLE;
          strobe.clrDone = 1'b1;
        end
      end
      default: phaseNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/tgsDatapath.sv
module tgsDatapath
  import tgsPkg::*;
#(
  parameter int TASKS = NUM_TASKS
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  output logic [TASKS-1:0] taskReq,
  output logic             appDone
);

  for (genvar t = 0; t < TASKS; t++) begin : g_pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) taskReq[t] <= 1'b0;
      else       taskReq[t] <= strobe.start[t];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               appDone <= 1'b0;
    else if (strobe.clrDone) appDone <= 1'b0;
    else if (strobe.setDone) appDone <= 1'b1;
  end

endmodule

// File: rtl/taskGraphSeq.sv
module taskGraphSeq
  import tgsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       appReq,
  input  logic [3:0] finish,
  output logic [3:0] taskReq,
  output logic       appDone
);

  strobe_t strobe;
  phase_t  phase;

  tgsControl u_control (
    .clk    (clk),
    .rstN   (rstN),
    .appReq (appReq),
    .finish (finish),
    .strobe (strobe),
    .phase  (phase)
  );

  tgsDatapath #(.TASKS(NUM_TASKS)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .taskReq (taskReq),
    .appDone (appDone)
  );

endmodule

// File: rtl/taskGraphSeqChk.sv
module taskGraphSeqChk
  import tgsPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       appReq,
  input logic [3:0] taskReq,
  input logic       appDone,
  input phase_t     phase
);

  // R1: reset clears every output
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (taskReq == 4'b0000 && !appDone));

  // R2: request in idle starts task A
  a_r2_start_a: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_IDLE && appReq) |=> (taskReq == 4'b0001));

  // R3: B and C always requested together
  a_r3_b_with_c: assert property (@(posedge clk) disable iff (!rstN)
    taskReq[1] |-> taskReq[2]);
  a_r3_c_with_b: assert property (@(posedge clk) disable iff (!rstN)
    taskReq[2] |-> taskReq[1]);

  // R5: D requested alone
  a_r5_d_alone: assert property (@(posedge clk) disable iff (!rstN)
    taskReq[3] |-> (taskReq[2:0] == 3'b000));

  // R6: single-cycle pulses
  for (genvar t = 0; t < 4; t++) begin : g_r6
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
      taskReq[t] |=> !taskReq[t]);
  end

  // R8: done holds and is quiet
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (appDone && !appReq) |=> appDone);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    appDone |-> (taskReq == 4'b0000));

  // R9: request in the terminal state clears done without a start
  a_r9_done_leave: assert property (@(posedge clk) disable iff (!rstN)
    (appDone && appReq) |=> (!appDone && taskReq == 4'b0000));

endmodule

bind taskGraphSeq taskGraphSeqChk chk (
  .clk     (clk),
  .rstN    (rstN),
  .appReq  (appReq),
  .taskReq (taskReq),
  .appDone (appDone),
  .phase   (phase)
);

// File: tb/taskGraphSeq_test.sv
`timescale 1ns/1ps
module taskGraphSeq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       appReq = 1'b0;
  logic [3:0] finish = 4'b0000;
  logic [3:0] taskReq;
  logic       appDone;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic       mIdle, mDone, mA1Done, mA2Done, mCDone;
  logic [3:0] mRun;
  logic [3:0] eReq, prevReq;
  logic       eDone;

  always #2.5 clk = ~clk;

  taskGraphSeq uut (
    .clk     (clk),
    .rstN    (rstN),
    .appReq  (appReq),
    .finish  (finish),
    .taskReq (taskReq),
    .appDone (appDone)
  );

  task automatic modelReset();
    mIdle = 1'b1; mDone = 1'b0; mA1Done = 1'b0; mA2Done = 1'b0; mCDone = 1'b0;
    mRun = 4'b0000; eReq = 4'b0000; eDone = 1'b0; prevReq = 4'b0000;
  endtask

  task automatic modelStep(input logic rq, input logic [3:0] f);
    logic [3:0] acc;
    logic joinBefore;
    eReq = 4'b0000;
    if (mIdle) begin
      if (rq) begin
        mIdle = 1'b0; mRun = 4'b0001; mA1Done = 1'b0; mA2Done = 1'b0; mCDone = 1'b0;
        eReq[0] = 1'b1;
      end
    end else if (mDone) begin
      if (rq) begin mDone = 1'b0; mIdle = 1'b1; end
    end else begin
      acc = f & mRun;
      mRun = mRun & ~acc;
      joinBefore = mA2Done && mCDone;
      if (acc[0] && !mA1Done) begin
        mA1Done = 1'b1; mRun = mRun | 4'b0110; eReq = eReq | 4'b0110;
      end else if (acc[0]) begin
        mA2Done = 1'b1;
      end
      if (acc[1]) begin mRun[0] = 1'b1; eReq[0] = 1'b1; end
      if (acc[2]) mCDone = 1'b1;
      if (!joinBefore && mA2Done && mCDone) begin mRun[3] = 1'b1; eReq[3] = 1'b1; end
      if (acc[3]) mDone = 1'b1;
    end
    eDone = mDone;
  endtask

  task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, advance one edge, compare against the model
  task automatic step(input logic rq, input logic [3:0] f);
    appReq = rq; finish = f;
    modelStep(rq, f);
    @(posedge clk); #1;
    appReq = 1'b0; finish = 4'b0000;
    check(taskReq[0] == eReq[0], "R4", {appDone, taskReq}, {eDone, eReq});
    check(taskReq[2:1] == eReq[2:1], "R3", {appDone, taskReq}, {eDone, eReq});
    check(taskReq[3] == eReq[3], "R5", {appDone, taskReq}, {eDone, eReq});
    check(appDone == eDone, "R8", {appDone, taskReq}, {eDone, eReq});
    check((taskReq & prevReq) == 4'b0000, "R6", {1'b0, taskReq}, {1'b0, prevReq & ~taskReq});
    prevReq = taskReq;
  endtask

  task automatic expectNow(input string tag, input logic [3:0] r, input logic d);
    check(taskReq == r && appDone == d, tag, {appDone, taskReq}, {d, r});
  endtask

  task automatic doReset();
    rstN = 1'b0; appReq = 1'b0; finish = 4'b0000;
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    expectNow("R1", 4'b0000, 1'b0);
    rstN = 1'b1;
    @(posedge clk); #1;
    expectNow("R1", 4'b0000, 1'b0);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    doReset();

    // R7: stray finishes in idle are ignored
    step(1'b0, 4'b1111); expectNow("R7", 4'b0000, 1'b0);
    // path: B before C, then C, then second A
    step(1'b1, 4'b0000); expectNow("R2", 4'b0001, 1'b0);
    step(1'b1, 4'b1110); expectNow("R7", 4'b0000, 1'b0);
    step(1'b0, 4'b0001); expectNow("R3", 4'b0110, 1'b0);
    step(1'b0, 4'b0000); expectNow("R6", 4'b0000, 1'b0);
    step(1'b0, 4'b1011); expectNow("R4", 4'b0001, 1'b0);
    step(1'b0, 4'b0100); expectNow("R5", 4'b0000, 1'b0);
    step(1'b0, 4'b0001); expectNow("R5", 4'b1000, 1'b0);
    step(1'b0, 4'b0111); expectNow("R7", 4'b0000, 1'b0);
    step(1'b0, 4'b1000); expectNow("R8", 4'b0000, 1'b1);
    step(1'b0, 4'b1111); expectNow("R8", 4'b0000, 1'b1);
    step(1'b1, 4'b0000); expectNow("R9", 4'b0000, 1'b0);
    step(1'b0, 4'b0000); expectNow("R9", 4'b0000, 1'b0);
    // path: B and C tie
    step(1'b1, 4'b0000); expectNow("R9", 4'b0001, 1'b0);
    step(1'b0, 4'b0001);
    step(1'b0, 4'b0110); expectNow("R4", 4'b0001, 1'b0);
    step(1'b0, 4'b0001); expectNow("R5", 4'b1000, 1'b0);
    step(1'b0, 4'b1000);
    step(1'b1, 4'b0000);
    // path: C before B, then A and C tie impossible; A second finishes
    step(1'b1, 4'b0000);
    step(1'b0, 4'b0001);
    step(1'b0, 4'b0100); expectNow("R4", 4'b0000, 1'b0);
    step(1'b0, 4'b0010); expectNow("R4", 4'b0001, 1'b0);
    step(1'b0, 4'b0001); expectNow("R5", 4'b1000, 1'b0);
    step(1'b0, 4'b1000);
    step(1'b1, 4'b0000);
    // path: B first, then second A and C finish together
    step(1'b1, 4'b0000);
    step(1'b0, 4'b0001);
    step(1'b0, 4'b0010);
    step(1'b0, 4'b0101); expectNow("R5", 4'b1000, 1'b0);
    step(1'b0, 4'b1000); expectNow("R8", 4'b0000, 1'b1);
    // path: B first, second A before C
    step(1'b1, 4'b0000);
    step(1'b1, 4'b0000);
    step(1'b0, 4'b0001);
    step(1'b0, 4'b0010);
    step(1'b0, 4'b0001); expectNow("R5", 4'b0000, 1'b0);
    step(1'b0, 4'b0100); expectNow("R5", 4'b1000, 1'b0);
    step(1'b0, 4'b1000);

    // constrained random mix with a mid-run reset
    for (int i = 0; i < 6000; i++) begin
      logic rq;
      logic [3:0] f;
      rq = ($urandom % 6) == 0;
      for (int b = 0; b < 4; b++) f[b] = ($urandom % 3) == 0;
      step(rq, f);
      if (i == 3000) doReset();
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule